// File: doc/BRIEF.md
# Message Data Buffer Pointer Manager

After each message, this block works out where the data for the next message goes. It takes the descriptor block loaded for the command: a control word and three buffer words. It also takes the result of the message just processed, which is the number of data words and a success flag. The low two bits of the control word pick one of four buffering disciplines. These are a counted single buffer, a two-buffer alternation, a circular buffer that holds message information in line with the data, and a circular buffer with a separate information area. The block returns the updated descriptor words for write-back, the data address for the next message, and two host interrupt requests.

One transaction is one message result. The result enters on a valid/ready handshake, and the block holds one updated result on a second valid/ready handshake. A result is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output holds nothing or the output is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, every output stays frozen and no new result is accepted.

Top module: `bufptr_mgr`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid`, `irq_msg` and `irq_done` are low.
- R2: `in_ready` equals `!out_valid || out_ready`. When the output is stalled, all outputs keep their values until it is taken.
- R3: Control bits [1:0] select the discipline: 00 counted single buffer, 01 two-buffer alternation, 10 circular with inline information, 11 circular with a separate information area. Every update follows the discipline selected by the accepted control word.
- R4: If the message failed (`msg_ok` low), the written-back words equal the loaded words, both interrupts are low, and `next_addr` is the current data address of the discipline.
- R5: Counted single buffer (w1 = data pointer, w2 = remaining count). On success with a nonzero count, the count drops by one and the pointer advances by the word count. `irq_done` is raised when the count goes from 1 to 0 and control bit 6 is set. With a count of zero, nothing changes and no `irq_done` is raised. `next_addr` is the updated pointer.
- R6: Two-buffer alternation (w1 = buffer A, w2 = buffer B). A successful message inverts control bit 5. `next_addr` is w2 when the updated bit 5 is 1, and w1 otherwise.
- R7: Circular with inline information (w1 = pointer, w2 = start, w3 = end). On success the new pointer is w1 + word count + 2. If that value exceeds w3, the pointer becomes w2 and `irq_done` follows control bit 6. `next_addr` is the new pointer.
- R8: Circular with separate area (w1 = data pointer, w2 = remaining count, w3 = information pointer). The buffers are aligned blocks of 2^k words, where k is control bits [11:8]. On success the data pointer advances by the word count and the information pointer advances by 2. Each stays inside its own block, wrapping modulo 2^k. A nonzero count drops by one, and `irq_done` follows control bit 6 when the count reaches zero.
- R9: `irq_msg` is high for a successful message exactly when control bit 4 is set. Control bits other than bit 5 are written back unchanged.
- R10: The updated result appears on the outputs with `out_valid` high on the clock edge that follows acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Message result and descriptor are valid |
| in_ready | output | 1 | Block can accept a result |
| d_ctrl | input | DW | Loaded control word |
| d_w1 | input | DW | Loaded descriptor word 1 |
| d_w2 | input | DW | Loaded descriptor word 2 |
| d_w3 | input | DW | Loaded descriptor word 3 |
| msg_wc | input | WCW | Data words in the message |
| msg_ok | input | 1 | Message completed successfully |
| out_valid | output | 1 | Updated result is held |
| out_ready | input | 1 | Consumer takes the result |
| wb_ctrl | output | DW | Control word to write back |
| wb_w1 | output | DW | Word 1 to write back |
| wb_w2 | output | DW | Word 2 to write back |
| wb_w3 | output | DW | Word 3 to write back |
| next_addr | output | DW | Data address for the next message |
| irq_msg | output | 1 | Per-message interrupt request |
| irq_done | output | 1 | Count-exhausted or buffer-wrap interrupt request |

## Verification
The stimulus draws every discipline with counts of 0, 1 and 2. This separates decrementing, finishing and frozen counters. Circular pointers start close to their end address or block edge, and word counts run from 0 to 32, so both wrapping and non-wrapping advances occur. Failed messages are mixed in, which shows that a discipline has no side effects when it should not act. Random back-pressure on both handshakes separates a held output from a lost or duplicated one.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  typedef enum logic [1:0] {
    M_SINGLE = 2'b00,
    M_PINGPONG = 2'b01,
    M_CIRC_INLINE = 2'b10,
    M_CIRC_SPLIT = 2'b11
  } method_e;

  localparam int MSG_IE_BIT = 4;
  localparam int BUF_SEL_BIT = 5;
  localparam int END_IE_BIT = 6;
  localparam int SIZE_LSB = 8;
  localparam int SIZE_W = 4;
endpackage

// File: rtl/bpm_wrap_step.sv
module bpm_wrap_step #(
  parameter int AW = 16,
  parameter int SW = 4
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] inc,
  input  logic [SW-1:0] size_log2,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] mask;
  logic [AW:0]   sum;

  always_comb begin
    mask = (AW'(1) << size_log2) - AW'(1);
    sum  = {1'b0, ptr & mask} + {1'b0, inc};
    nxt  = (ptr & ~mask) | (sum[AW-1:0] & mask);
  end
endmodule

// File: rtl/bpm_update.sv
module bpm_update
  import bpm_pkg::*;
#(
  parameter int DW = 16,
  parameter int WCW = 6,
  parameter int INFO_WORDS = 2
) (
  input  logic [DW-1:0]  ctrl,
  input  logic [DW-1:0]  w1,
  input  logic [DW-1:0]  w2,
  input  logic [DW-1:0]  w3,
  input  logic [WCW-1:0] wc,
  input  logic           ok,
  output logic [DW-1:0]  n_ctrl,
  output logic [DW-1:0]  n_w1,
  output logic [DW-1:0]  n_w2,
  output logic [DW-1:0]  n_w3,
  output logic [DW-1:0]  n_addr,
  output logic           i_msg,
  output logic           i_done
);
  localparam int NSTEP = 2;

  method_e       method;
  logic [DW-1:0] wc_ext;
  logic [DW:0]   inline_sum;
  logic          cnt_live;
  logic          cnt_last;
  logic [DW-1:0] step_ptr [NSTEP];
  logic [DW-1:0] step_inc [NSTEP];
  logic [DW-1:0] step_nxt [NSTEP];

  assign method   = method_e'(ctrl[1:0]);
  assign wc_ext   = DW'(wc);
  assign cnt_live = (w2 != '0);
  assign cnt_last = (w2 == DW'(1));
  assign inline_sum = {1'b0, w1} + {1'b0, wc_ext} + (DW+1)'(INFO_WORDS);

  // data pointer (0) and information pointer (1) of the split circular mode
  assign step_ptr[0] = w1;
  assign step_ptr[1] = w3;
  assign step_inc[0] = wc_ext;
  assign step_inc[1] = DW'(INFO_WORDS);

  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    bpm_wrap_step #(.AW(DW), .SW(SIZE_W)) u_step (
      .ptr(step_ptr[g]),
      .inc(step_inc[g]),
      .size_log2(ctrl[SIZE_LSB +: SIZE_W]),
      .nxt(step_nxt[g])
    );
  end

  always_comb begin
    n_ctrl = ctrl;
    n_w1   = w1;
    n_w2   = w2;
    n_w3   = w3;
    i_msg  = ok & ctrl[MSG_IE_BIT];
    i_done = 1'b0;
    unique case (method)
      M_SINGLE: begin
        if (ok && cnt_live) begin
          n_w2   = w2 - DW'(1);
          n_w1   = w1 + wc_ext;
          i_done = cnt_last & ctrl[END_IE_BIT];
        end
      end
      M_PINGPONG: begin
        if (ok) n_ctrl[BUF_SEL_BIT] = ~ctrl[BUF_SEL_BIT];
      end
      M_CIRC_INLINE: begin
        if (ok) begin
          if (inline_sum > {1'b0, w3}) begin
            n_w1   = w2;
            i_done = ctrl[END_IE_BIT];
          end else begin
            n_w1 = inline_sum[DW-1:0];
          end
        end
      end
      M_CIRC_SPLIT: begin
        if (ok) begin
          n_w1 = step_nxt[0];
          n_w3 = step_nxt[1];
          if (cnt_live) begin
            n_w2   = w2 - DW'(1);
            i_done = cnt_last & ctrl[END_IE_BIT];
          end
        end
      end
      default: ;
    endcase
    n_addr = (method == M_PINGPONG) ? (n_ctrl[BUF_SEL_BIT] ? w2 : w1) : n_w1;
  end
endmodule

// File: rtl/bpm_hold_stage.sv
module bpm_hold_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end
endmodule

// File: rtl/bufptr_mgr.sv
module bufptr_mgr #(
  parameter int DW = 16,
  parameter int WCW = 6,
  parameter int INFO_WORDS = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  d_ctrl,
  input  logic [DW-1:0]  d_w1,
  input  logic [DW-1:0]  d_w2,
  input  logic [DW-1:0]  d_w3,
  input  logic [WCW-1:0] msg_wc,
  input  logic           msg_ok,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  wb_ctrl,
  output logic [DW-1:0]  wb_w1,
  output logic [DW-1:0]  wb_w2,
  output logic [DW-1:0]  wb_w3,
  output logic [DW-1:0]  next_addr,
  output logic           irq_msg,
  output logic           irq_done
);
  localparam int PW = 5 * DW + 2;

  logic [DW-1:0] u_ctrl, u_w1, u_w2, u_w3, u_addr;
  logic          u_msg, u_done;
  logic [PW-1:0] pay_in, pay_out;

  bpm_update #(.DW(DW), .WCW(WCW), .INFO_WORDS(INFO_WORDS)) u_upd (
    .ctrl(d_ctrl), .w1(d_w1), .w2(d_w2), .w3(d_w3),
    .wc(msg_wc), .ok(msg_ok),
    .n_ctrl(u_ctrl), .n_w1(u_w1), .n_w2(u_w2), .n_w3(u_w3),
    .n_addr(u_addr), .i_msg(u_msg), .i_done(u_done)
  );

  assign pay_in = {u_ctrl, u_w1, u_w2, u_w3, u_addr, u_msg, u_done};

  bpm_hold_stage #(.W(PW)) u_hold (
    .clk(clk), .rst(rst),
    .s_valid(in_valid), .s_ready(in_ready), .s_data(pay_in),
    .m_valid(out_valid), .m_ready(out_ready), .m_data(pay_out)
  );

  logic msg_q, done_q;
  assign {wb_ctrl, wb_w1, wb_w2, wb_w3, next_addr, msg_q, done_q} = pay_out;
  assign irq_msg  = out_valid & msg_q;
  assign irq_done = out_valid & done_q;
endmodule

// File: rtl/bpm_props.sv
module bpm_props #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] d_ctrl,
  input logic [DW-1:0] d_w1,
  input logic [DW-1:0] d_w2,
  input logic          msg_ok,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] wb_ctrl,
  input logic [DW-1:0] wb_w1,
  input logic [DW-1:0] wb_w2,
  input logic [DW-1:0] next_addr,
  input logic          irq_msg,
  input logic          irq_done
);
  logic take;
  assign take = in_valid && in_ready;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(wb_w1) && $stable(next_addr) && $stable(wb_ctrl)) // R2
    else $error("stalled output changed");

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid) // R10
    else $error("accepted result not presented");

  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (rst)
    take && !msg_ok |=> !irq_msg && !irq_done && wb_w1 == $past(d_w1) && wb_w2 == $past(d_w2)) // R4
    else $error("failed message changed state");

  AST_PP_FLIP: assert property (@(posedge clk) disable iff (rst)
    take && msg_ok && d_ctrl[1:0] == 2'b01 |=> wb_ctrl[5] != $past(d_ctrl[5])) // R6
    else $error("buffer select not inverted");

  AST_SINGLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    take && d_ctrl[1:0] == 2'b00 && d_w2 == '0 |=> !irq_done && wb_w1 == $past(d_w1) && wb_w2 == '0) // R5
    else $error("exhausted counter moved");

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !irq_msg && !irq_done) // R1
    else $error("interrupt without result");
endmodule

bind bufptr_mgr bpm_props #(.DW(DW)) u_props (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .d_ctrl(d_ctrl), .d_w1(d_w1), .d_w2(d_w2), .msg_ok(msg_ok),
  .out_valid(out_valid), .out_ready(out_ready),
  .wb_ctrl(wb_ctrl), .wb_w1(wb_w1), .wb_w2(wb_w2), .next_addr(next_addr),
  .irq_msg(irq_msg), .irq_done(irq_done)
);

// File: tb/bufptr_mgr_test.sv
`timescale 1ns/1ps
module bufptr_mgr_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0, msg_ok = 1'b0;
  logic [15:0] d_ctrl = '0, d_w1 = '0, d_w2 = '0, d_w3 = '0;
  logic [5:0] msg_wc = '0;
  logic in_ready, out_valid, irq_msg, irq_done;
  logic [15:0] wb_ctrl, wb_w1, wb_w2, wb_w3, next_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bufptr_mgr uut (.*);

  // expected output register of the reference model
  bit e_valid = 0;
  int e_ctrl, e_w1, e_w2, e_w3, e_addr, e_msg, e_done, e_meth;

  task automatic model(input int c, input int a, input int b, input int d, input int wc, input bit ok);
    int m, sz, base;
    m = c & 3; // R3: discipline from bits [1:0]
    e_meth = m; e_ctrl = c; e_w1 = a; e_w2 = b; e_w3 = d;
    e_msg = (ok && ((c >> 4) & 1)) ? 1 : 0;
    e_done = 0;
    if (ok) begin
      if (m == 0 && b != 0) begin
        e_w2 = b - 1; e_w1 = (a + wc) & 16'hFFFF;
        if (b == 1 && ((c >> 6) & 1)) e_done = 1;
      end else if (m == 1) begin
        e_ctrl = c ^ 32;
      end else if (m == 2) begin
        if (a + wc + 2 > d) begin e_w1 = b; e_done = (c >> 6) & 1; end
        else e_w1 = a + wc + 2;
      end else if (m == 3) begin
        sz = 1 << ((c >> 8) & 15);
        base = a - (a % sz); e_w1 = base + ((a % sz) + wc) % sz;
        base = d - (d % sz); e_w3 = base + ((d % sz) + 2) % sz;
        if (b != 0) begin e_w2 = b - 1; if (b == 1) e_done = (c >> 6) & 1; end
      end
    end
    if (m == 1) e_addr = ((e_ctrl >> 5) & 1) ? b : a;
    else e_addr = e_w1;
  endtask

  always @(posedge clk) begin
    if (rst) e_valid = 0;
    else if (in_valid && (!e_valid || out_ready)) begin
      model(d_ctrl, d_w1, d_w2, d_w3, msg_wc, msg_ok);
      e_valid = 1;
    end else if (e_valid && out_ready) e_valid = 0;
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mtag(input int m);
    case (m)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  // compare against the model on every falling edge
  always @(negedge clk) if (!rst && !done) begin
    chk(out_valid === e_valid, "R10 out_valid", out_valid, e_valid);
    chk(in_ready === (!e_valid || out_ready), "R2 in_ready", in_ready, !e_valid || out_ready);
    if (e_valid) begin
      chk(wb_ctrl === 16'(e_ctrl), "R9/R6 wb_ctrl", wb_ctrl, e_ctrl);
      chk(wb_w1 === 16'(e_w1), mtag(e_meth), wb_w1, e_w1);
      chk(wb_w2 === 16'(e_w2), mtag(e_meth), wb_w2, e_w2);
      chk(wb_w3 === 16'(e_w3), mtag(e_meth), wb_w3, e_w3);
      chk(next_addr === 16'(e_addr), {"R3 next_addr ", mtag(e_meth)}, next_addr, e_addr);
      chk(irq_msg === e_msg[0], "R9 irq_msg", irq_msg, e_msg);
      chk(irq_done === e_done[0], {"R4 irq_done ", mtag(e_meth)}, irq_done, e_done);
    end else begin
      chk(irq_msg === 1'b0 && irq_done === 1'b0, "R1 idle irqs", {irq_msg, irq_done}, 0);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && irq_msg === 1'b0 && irq_done === 1'b0, "R1 reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 after reset", out_valid, 0);
    for (int i = 0; i < 6000; i++) begin
      int m;
      m = i % 4;
      in_valid = ($urandom % 4) != 0;
      out_ready = (i > 100 && i < 140) ? 1'b0 : (($urandom % 3) != 0);
      msg_ok = ($urandom % 5) != 0; // R4: some failures
      msg_wc = 6'($urandom % 33);
      d_ctrl = 16'($urandom);
      d_ctrl[1:0] = 2'(m);
      d_w1 = 16'($urandom); d_w2 = 16'($urandom); d_w3 = 16'($urandom);
      if (m == 0 || m == 3) d_w2 = 16'($urandom % 3);
      if (m == 2) begin
        d_w2 = 16'h0100; d_w3 = 16'h013F; d_w1 = 16'h0100 + 16'($urandom % 64);
      end
      if (m == 3) begin
        d_ctrl[11:8] = 4'(2 + $urandom % 5);
      end
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule